// File: doc/BRIEF.md
# Two-Wire Slave Address Recognizer

This block looks at the address byte of a two-wire serial bus transaction and decides whether the local device is being addressed. A shift-register front end delivers the first byte received after a START condition and pulses a completion strobe. The recognizer compares the upper seven bits against a software-programmed own address. If the byte is the all-zero broadcast address, it counts only when broadcast recognition is enabled. The lowest bit of the byte is the transfer direction and takes no part in the comparison.

On a hit the block raises an event flag, captures what kind of hit it was and presents a status code. It holds the bus handler stalled until software acknowledges by writing 1 to the flag. The interrupt request is the flag gated by a local enable and a global enable. With the local enable low, software polls the flag instead.

Top module: `twAddrRecog`

## Requirements
- R1: After reset the address register reads 0xFE, the event flag, match outputs, direction, hold and interrupt request are 0, and the status reads 0xF8.
- R2: A register write (`regWrEn` high at a clock edge) loads `regWrData`, visible on `addrRegQ` after that edge. Bits 7..1 are the own address and bit 0 is the broadcast enable (1 = enabled). A byte accepted in the same cycle is compared against the old value.
- R3: With the flag clear, an accepted byte whose bits 7..1 equal a nonzero own address sets the flag and `matchOwn` after that edge. Bit 0 of the received byte is ignored by the comparison and is captured on `dirRead` (1 = read).
- R4: A received byte with bits 7..1 all zero sets the flag and `matchGenCall` only when the broadcast enable is 1. With the enable at 0 it has no effect, even when the own address is programmed to zero.
- R5: A received byte that matches neither the own address nor an enabled broadcast leaves the flag, the match outputs, `dirRead` and the status unchanged.
- R6: While the flag is set, `status` reads 0x60 for an own-address write (direction 0), 0xA8 for an own-address read (direction 1) and 0x70 for a broadcast. While the flag is clear it reads 0xF8.
- R7: Writing 1 to the flag (`flagWrEn` with `flagWrData`=1) clears the flag, the match outputs and `dirRead` after that edge. Writing 0 changes nothing.
- R8: While the flag is set, `busHold` is 1 and further completion strobes are ignored. `busHold` is 0 while the flag is clear.
- R9: `irq` is 1 exactly when the flag, `intEnLocal` and `intEnGlobal` are all 1, combinationally from the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Address register write strobe |
| regWrData | input | 8 | Address register write value |
| addrRegQ | output | 8 | Current address register contents |
| rxByte | input | 8 | First byte received after START |
| rxValid | input | 1 | Strobe marking rxByte complete |
| flagWrEn | input | 1 | Event flag write strobe |
| flagWrData | input | 1 | Event flag write value (1 clears) |
| intEnLocal | input | 1 | Local interrupt enable |
| intEnGlobal | input | 1 | Global interrupt enable |
| eventFlag | output | 1 | Event pending flag |
| matchOwn | output | 1 | Own address was recognized |
| matchGenCall | output | 1 | Broadcast address was recognized |
| dirRead | output | 1 | Captured direction bit (1 = read) |
| status | output | 8 | Bus state code |
| busHold | output | 1 | Stall request to the bus handler |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench drives the all-zero address in three settings: broadcast enabled, broadcast disabled, and own address programmed to zero with broadcast disabled. A design that treated a zero own address as an ordinary match, or ignored the enable, would raise the flag where it must not. It also sends the own address with both direction bits, so a design that folded bit 0 into the compare would miss one of them, and one that mixed up the direction would swap the 0x60 and 0xA8 codes. Strobes that arrive while the flag is pending, and writes of 0 to the flag, are checked to leave status and capture untouched. A design that kept advancing or cleared on any write would show changed outputs. A register write in the same cycle as a byte checks that the old address is used.

// File: rtl/twAddrPkg.sv
package twAddrPkg;
  localparam logic [7:0] ST_OWN_WRITE = 8'h60;
  localparam logic [7:0] ST_OWN_READ  = 8'hA8;
  localparam logic [7:0] ST_GEN_CALL  = 8'h70;
  localparam logic [7:0] ST_NONE      = 8'hF8;

  typedef struct packed {
    logic loadMatch;
    logic clrMatch;
  } ctrlStrobes_t;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_HOLD = 1'b1
  } ctrlState_t;
endpackage

// File: rtl/twAddrDatapath.sv
module twAddrDatapath
  import twAddrPkg::*;
#(
  parameter int ADDR_W = 7,
  localparam int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] rxByte,
  input  ctrlStrobes_t      strobes,
  input  logic              flagQ,
  output logic [BYTE_W-1:0] addrRegQ,
  output logic              ownHit,
  output logic              genHit,
  output logic              matchOwn,
  output logic              matchGenCall,
  output logic              dirRead,
  output logic [7:0]        status
);
  logic [BYTE_W-1:0] addrReg;
  logic [ADDR_W-1:0] bitEq;
  logic [ADDR_W-1:0] bitZero;
  logic              addrEqual;
  logic              rxAllZero;
  logic              ownQ;
  logic              genQ;
  logic              dirQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= {{ADDR_W{1'b1}}, 1'b0};
    end else if (regWrEn) begin
      addrReg <= regWrData;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : gCmp
      assign bitEq[gi]   = ~(rxByte[gi+1] ^ addrReg[gi+1]);
      assign bitZero[gi] = ~rxByte[gi+1];
    end
  endgenerate

  assign addrEqual = &bitEq;
  assign rxAllZero = &bitZero;
  assign ownHit    = addrEqual && !rxAllZero;
  assign genHit    = rxAllZero && addrReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownQ <= 1'b0;
      genQ <= 1'b0;
      dirQ <= 1'b0;
    end else if (strobes.loadMatch) begin
      ownQ <= ownHit;
      genQ <= genHit;
      dirQ <= rxByte[0];
    end else if (strobes.clrMatch) begin
      ownQ <= 1'b0;
      genQ <= 1'b0;
      dirQ <= 1'b0;
    end
  end

  always_comb begin
    if (!flagQ)     status = ST_NONE;
    else if (genQ)  status = ST_GEN_CALL;
    else if (dirQ)  status = ST_OWN_READ;
    else            status = ST_OWN_WRITE;
  end

  assign addrRegQ     = addrReg;
  assign matchOwn     = ownQ;
  assign matchGenCall = genQ;
  assign dirRead      = dirQ;
endmodule

// File: rtl/twAddrControl.sv
module twAddrControl
  import twAddrPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxValid,
  input  logic         ownHit,
  input  logic         genHit,
  input  logic         flagWrEn,
  input  logic         flagWrData,
  input  logic         intEnLocal,
  input  logic         intEnGlobal,
  output ctrlStrobes_t strobes,
  output logic         flagQ,
  output logic         busHold,
  output logic         irq
);
  ctrlState_t state;
  ctrlState_t stateNext;
  logic       accept;
  logic       ack;

  assign accept = (state == CS_IDLE) && rxValid && (ownHit || genHit);
  assign ack    = (state == CS_HOLD) && flagWrEn && flagWrData;

  always_comb begin
    stateNext = state;
    case (state)
      CS_IDLE: if (accept) stateNext = CS_HOLD;
      CS_HOLD: if (ack)    stateNext = CS_IDLE;
      default: stateNext = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= CS_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.loadMatch = accept;
    strobes.clrMatch  = ack;
  end

  assign flagQ   = (state == CS_HOLD);
  assign busHold = flagQ;
  assign irq     = flagQ && intEnLocal && intEnGlobal;
endmodule

// File: rtl/twAddrRecog.sv
module twAddrRecog
  import twAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] addrRegQ,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       flagWrEn,
  input  logic       flagWrData,
  input  logic       intEnLocal,
  input  logic       intEnGlobal,
  output logic       eventFlag,
  output logic       matchOwn,
  output logic       matchGenCall,
  output logic       dirRead,
  output logic [7:0] status,
  output logic       busHold,
  output logic       irq
);
  ctrlStrobes_t strobes;
  logic         ownHit;
  logic         genHit;
  logic         flagQ;

  twAddrDatapath #(.ADDR_W(7)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .rxByte(rxByte), .strobes(strobes), .flagQ(flagQ), .addrRegQ(addrRegQ),
    .ownHit(ownHit), .genHit(genHit), .matchOwn(matchOwn),
    .matchGenCall(matchGenCall), .dirRead(dirRead), .status(status)
  );

  twAddrControl uCtl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .ownHit(ownHit),
    .genHit(genHit), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .intEnLocal(intEnLocal), .intEnGlobal(intEnGlobal), .strobes(strobes),
    .flagQ(flagQ), .busHold(busHold), .irq(irq)
  );

  assign eventFlag = flagQ;
endmodule

// File: rtl/twAddrRecogChk.sv
module twAddrRecogChk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addrRegQ,
  input logic [7:0] rxByte,
  input logic       rxValid,
  input logic       flagWrEn,
  input logic       flagWrData,
  input logic       intEnLocal,
  input logic       intEnGlobal,
  input logic       eventFlag,
  input logic       matchOwn,
  input logic       dirRead,
  input logic [7:0] status,
  input logic       busHold,
  input logic       irq
);
  AST_OWN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !eventFlag && rxByte[7:1] == addrRegQ[7:1] && rxByte[7:1] != 7'd0)
      |=> (eventFlag && matchOwn && dirRead == $past(rxByte[0]))); // R3

  AST_GC_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !eventFlag && rxByte[7:1] == 7'd0 && !addrRegQ[0]) |=> !eventFlag); // R4

  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !eventFlag |-> status == 8'hF8); // R6

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && !(flagWrEn && flagWrData)) |=> eventFlag); // R7

  AST_IGNORE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && rxValid && !(flagWrEn && flagWrData)) |=> ($stable(status) && $stable(dirRead))); // R8

  AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    busHold == eventFlag); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (eventFlag && intEnLocal && intEnGlobal)); // R9

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    (eventFlag && intEnLocal && intEnGlobal) |-> irq); // R9
endmodule

bind twAddrRecog twAddrRecogChk uChk (.*);

// File: tb/sim_twAddrRecog.sv
`timescale 1ns/1ps
module sim_twAddrRecog;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] addrRegQ;
  logic [7:0] rxByte = 8'h00;
  logic       rxValid = 1'b0;
  logic       flagWrEn = 1'b0;
  logic       flagWrData = 1'b0;
  logic       intEnLocal = 1'b0;
  logic       intEnGlobal = 1'b0;
  logic       eventFlag, matchOwn, matchGenCall, dirRead, busHold, irq;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  twAddrRecog u0 (.*);

  // reference model state
  int mAddr, mFlag, mOwn, mGen, mDir;

  function automatic int expStatus();
    if (mFlag == 0) return 8'hF8;
    if (mGen != 0) return 8'h70;
    if (mDir != 0) return 8'hA8;
    return 8'h60;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAddr = 8'hFE; mFlag = 0; mOwn = 0; mGen = 0; mDir = 0;
    end else begin
      int a7, own7;
      a7 = int'(rxByte[7:1]);
      own7 = mAddr / 2;
      if (rxValid && mFlag == 0) begin
        if (a7 != 0 && a7 == own7) begin
          mFlag = 1; mOwn = 1; mGen = 0; mDir = int'(rxByte[0]);
        end else if (a7 == 0 && (mAddr % 2) == 1) begin
          mFlag = 1; mOwn = 0; mGen = 1; mDir = int'(rxByte[0]);
        end
      end else if (mFlag != 0 && flagWrEn && flagWrData) begin
        mFlag = 0; mOwn = 0; mGen = 0; mDir = 0;
      end
      if (regWrEn) mAddr = int'(regWrData);
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R2 addrRegQ", int'(addrRegQ), mAddr);
      chk("R3 eventFlag", int'(eventFlag), mFlag);
      chk("R3 matchOwn", int'(matchOwn), mOwn);
      chk("R4 matchGenCall", int'(matchGenCall), mGen);
      chk("R3 dirRead", int'(dirRead), mDir);
      chk("R6 status", int'(status), expStatus());
      chk("R8 busHold", int'(busHold), mFlag);
      chk("R9 irq", int'(irq), (mFlag != 0 && intEnLocal && intEnGlobal) ? 1 : 0);
    end
  end

  task automatic stepEdge();
    @(posedge clk); #2;
    regWrEn = 1'b0; rxValid = 1'b0; flagWrEn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    rxByte = b; rxValid = 1'b1; stepEdge();
  endtask

  task automatic writeReg(input logic [7:0] v);
    regWrData = v; regWrEn = 1'b1; stepEdge();
  endtask

  task automatic writeFlag(input logic v);
    flagWrData = v; flagWrEn = 1'b1; stepEdge();
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    cmpOn = 1'b1;
    settle();
    // R1 reset values
    chk("R1 addr", int'(addrRegQ), 8'hFE);
    chk("R1 flag", int'(eventFlag), 0);
    chk("R1 status", int'(status), 8'hF8);
    chk("R1 irq", int'(irq), 0);
    chk("R1 hold", int'(busHold), 0);
    @(posedge clk); #2;

    writeReg(8'h54);                 // own 0x2A, broadcast off
    settle(); chk("R2 loaded", int'(addrRegQ), 8'h54);
    @(posedge clk); #2;

    sendRx(8'h54);                   // own address, write
    settle(); chk("R6 own write", int'(status), 8'h60);
    chk("R3 hit", int'(matchOwn), 1);
    @(posedge clk); #2;

    sendRx(8'h55);                   // pending: ignored
    settle(); chk("R8 ignored", int'(status), 8'h60);
    @(posedge clk); #2;

    writeFlag(1'b0);                 // no effect
    settle(); chk("R7 write0", int'(eventFlag), 1);
    @(posedge clk); #2;

    intEnLocal = 1'b1; settle(); chk("R9 local only", int'(irq), 0);
    @(posedge clk); #2;
    intEnGlobal = 1'b1; settle(); chk("R9 both", int'(irq), 1);
    @(posedge clk); #2;
    intEnLocal = 1'b0; settle(); chk("R9 global only", int'(irq), 0);
    @(posedge clk); #2;
    intEnLocal = 1'b1;

    writeFlag(1'b1);
    settle(); chk("R7 cleared", int'(eventFlag), 0);
    chk("R7 status", int'(status), 8'hF8);
    @(posedge clk); #2;

    sendRx(8'h55);                   // own address, read
    settle(); chk("R6 own read", int'(status), 8'hA8);
    chk("R3 dir", int'(dirRead), 1);
    @(posedge clk); #2;
    writeFlag(1'b1);

    sendRx(8'h56);                   // other address
    settle(); chk("R5 no match", int'(eventFlag), 0);
    @(posedge clk); #2;

    sendRx(8'h00);                   // broadcast disabled
    settle(); chk("R4 gc off", int'(eventFlag), 0);
    @(posedge clk); #2;

    writeReg(8'h55);                 // broadcast on
    sendRx(8'h00);
    settle(); chk("R4 gc on", int'(matchGenCall), 1);
    chk("R6 gc status", int'(status), 8'h70);
    @(posedge clk); #2;
    writeFlag(1'b1);
    sendRx(8'h01);
    settle(); chk("R4 gc read", int'(status), 8'h70);
    @(posedge clk); #2;
    writeFlag(1'b1);

    // same-cycle write and byte: old address 0x2A used
    regWrData = 8'h20; regWrEn = 1'b1; rxByte = 8'h54; rxValid = 1'b1;
    stepEdge();
    settle(); chk("R2 old addr used", int'(matchOwn), 1);
    chk("R2 new value", int'(addrRegQ), 8'h20);
    @(posedge clk); #2;
    writeFlag(1'b1);

    writeReg(8'h00);                 // own 0, broadcast off
    sendRx(8'h00);
    settle(); chk("R4 zero own", int'(eventFlag), 0);
    @(posedge clk); #2;
    sendRx(8'h01);
    settle(); chk("R4 zero own rd", int'(eventFlag), 0);
    @(posedge clk); #2;

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule